// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the synchronized input pins of a 32-pin general-purpose port into one interrupt line. Two configuration bits per pin select the trigger mode. A level-select bit picks level or edge detection, and a polarity bit picks active-high/rising or active-low/falling. When a pin is routed to the interrupt logic, a matching event latches that pin's status bit. The status bit stays set until software clears it. The port interrupt is raised while any latched status bit also has its enable bit set.

All five per-pin registers share one write port: routing, enable, level-select, polarity and status. Each write names a register and an alias. The plain alias replaces the register. The set alias ORs the data in, and the clear alias removes the bits that are one in the data. The status register is changed by software only through its clear alias. Reset brings every register to zero, which leaves the block quiet with no routed pin and no pending status.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the status vector and the interrupt output are zero, and no pin can latch status until it is routed.
- R2: Trigger code 0 (level-select 0, polarity 0) latches a pin's status one clock edge after the pin goes from 1 to 0; a 0-to-1 change in this mode latches nothing.
- R3: Trigger code 2 (level-select 0, polarity 1) latches status one clock edge after the pin goes from 0 to 1; a 1-to-0 change in this mode latches nothing.
- R4: Trigger code 1 (level-select 1, polarity 0) latches status on every clock edge while the pin is 0, so a clear does not remove the bit while the pin stays low.
- R5: Trigger code 3 (level-select 1, polarity 1) latches status on every clock edge while the pin is 1.
- R6: A pin whose routing bit is 0 never latches status, whatever its trigger mode and activity.
- R7: The interrupt output is 1 exactly when some pin has both its status bit and its enable bit at 1; the enable bit does not affect whether status latches.
- R8: Status bits fall only through a clear-alias write, which removes the bits written as 1; plain and set writes to the status register leave it unchanged.
- R9: Register select codes are routing 0, enable 1, level-select 2, polarity 3, status 4. Alias codes are plain 0, set 1 and clear 2. Alias code 3 writes nothing.
- R10: When a trigger event and a clear of the same status bit land on the same clock edge, the bit ends up set.
- R11: Changing a pin's trigger mode leaves its latched status bit unchanged.
- R12: In edge modes, a pin held steady produces no further event once its status is cleared, because each edge compares the pin with its value one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| pin_i | input | 32 | Synchronized pin levels from the port |
| wr_en_i | input | 1 | Register write strobe |
| wr_reg_i | input | 3 | Register select (R9 encoding) |
| wr_op_i | input | 2 | Write alias (R9 encoding) |
| wr_data_i | input | 32 | Write data, one bit per pin |
| status_o | output | 32 | Latched status bits |
| irq_o | output | 1 | Aggregated port interrupt |

## Verification
A register write changes its target on the clock edge that samples the strobe. The effect is visible on status_o and irq_o right after that edge. A pin change shows on status_o one edge later, because the edge history register and the status register are both updated on that edge. irq_o follows status and enable with no added register. The bench drives inputs one time unit after an edge and checks one time unit after the edge that completes the stimulus. Level-mode results are checked after a further edge, so that any latch caused by the new mode has taken place.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    REG_ROUTE    = 3'd0,
    REG_ENABLE   = 3'd1,
    REG_LEVEL    = 3'd2,
    REG_POLARITY = 3'd3,
    REG_STATUS   = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } wr_op_e;

  // bit 0 selects level detection, bit 1 selects high/rising
  typedef enum logic [1:0] {
    TRIG_FALL = 2'd0,
    TRIG_LOW  = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_HIGH = 2'd3
  } trig_e;

  localparam int NUM_CTRL = 4;

  // next value of one register bit under a write alias
  function automatic logic alias_bit(logic cur, logic din, wr_op_e op);
    logic nxt;
    case (op)
      OP_WRITE: nxt = din;
      OP_SET:   nxt = cur | din;
      OP_CLEAR: nxt = cur & ~din;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

  // whether a pin sample pair matches a trigger mode
  function automatic logic trig_hit(trig_e code, logic now, logic prev);
    logic hit;
    case (code)
      TRIG_FALL: hit = prev & ~now;
      TRIG_LOW:  hit = ~now;
      TRIG_RISE: hit = ~prev & now;
      default:   hit = now;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_reg_i,
  input  logic [1:0]       wr_op_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] route_o,
  output logic [WIDTH-1:0] enable_o,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] polar_o,
  output logic [WIDTH-1:0] clr_mask_o
);

  reg_sel_e sel;
  wr_op_e   op;
  logic [NUM_CTRL-1:0]    hit_reg;
  logic [WIDTH-1:0]       ctrl_q [NUM_CTRL];

  assign sel = reg_sel_e'(wr_reg_i);
  assign op  = wr_op_e'(wr_op_i);

  genvar r, b;
  generate
    for (r = 0; r < NUM_CTRL; r++) begin : g_reg
      assign hit_reg[r] = wr_en_i && (wr_reg_i == 3'(r));
      for (b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            ctrl_q[r][b] <= 1'b0;
          else if (hit_reg[r])
            ctrl_q[r][b] <= alias_bit(ctrl_q[r][b], wr_data_i[b], op);
        end
      end
    end
  endgenerate

  assign route_o  = ctrl_q[REG_ROUTE];
  assign enable_o = ctrl_q[REG_ENABLE];
  assign level_o  = ctrl_q[REG_LEVEL];
  assign polar_o  = ctrl_q[REG_POLARITY];

  // status is changed by software only through the clear alias
  always_comb begin
    clr_mask_o = '0;
    if (wr_en_i && sel == REG_STATUS && op == OP_CLEAR)
      clr_mask_o = wr_data_i;
  end

  // R9: reserved alias leaves every control register untouched
  a_r9_none_alias_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op == OP_NONE) |=>
      ($stable(route_o) && $stable(enable_o) && $stable(level_o) && $stable(polar_o)));

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic level_sel_i,
  input  logic polar_i,
  input  logic route_i,
  output logic set_o
);

  logic  pin_q;
  trig_e code;
  logic  hit;

  // previous sample for edge comparison
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  assign code  = trig_e'({polar_i, level_sel_i});
  assign hit   = trig_hit(code, pin_i, pin_q);
  assign set_o = route_i & hit;

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_mask_i,
  input  logic [WIDTH-1:0] clr_mask_i,
  input  logic [WIDTH-1:0] enable_i,
  input  logic [WIDTH-1:0] route_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] status_d;
  logic [WIDTH-1:0] pending;

  // set after clear: an event in the clearing cycle survives
  assign status_d = (status_q & ~clr_mask_i) | set_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign pending  = status_q & enable_i;
  assign irq_o    = |pending;
  assign status_o = status_q;

  // R8: a status bit falls only where a clear was written
  a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status_q & $past(status_q) & ~$past(clr_mask_i)) == '0));

  // R10: every requested set lands, even against a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask_i != '0) |=> ((status_q & $past(set_mask_i)) == $past(set_mask_i)));

  // R6: a status bit only rises on a routed pin
  a_r6_rise_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(route_i)) == '0));

  // R7: no interrupt without some latched status
  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_q != '0));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_reg_i,
  input  logic [1:0]       wr_op_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] route;
  logic [WIDTH-1:0] enable;
  logic [WIDTH-1:0] level_sel;
  logic [WIDTH-1:0] polar;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] set_mask;

  gpio_irq_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_reg_i   (wr_reg_i),
    .wr_op_i    (wr_op_i),
    .wr_data_i  (wr_data_i),
    .route_o    (route),
    .enable_o   (enable),
    .level_o    (level_sel),
    .polar_o    (polar),
    .clr_mask_o (clr_mask)
  );

  genvar p;
  generate
    for (p = 0; p < WIDTH; p++) begin : g_pin
      gpio_irq_pin u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i[p]),
        .level_sel_i (level_sel[p]),
        .polar_i     (polar[p]),
        .route_i     (route[p]),
        .set_o       (set_mask[p])
      );
    end
  endgenerate

  gpio_irq_status #(.WIDTH(WIDTH)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .enable_i   (enable),
    .route_i    (route),
    .status_o   (status_o),
    .irq_o      (irq_o)
  );

  // R1: nothing pending while held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (status_o == '0 && !irq_o));

endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;

  localparam int W = 32;
  localparam logic [2:0] RG_ROUTE = 3'd0, RG_EN = 3'd1, RG_LEV = 3'd2,
                         RG_POL = 3'd3, RG_STAT = 3'd4;
  localparam logic [1:0] A_WR = 2'd0, A_SET = 2'd1, A_CLR = 2'd2, A_NONE = 2'd3;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin = '1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_reg = '0;
  logic [1:0]   wr_op = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] status;
  logic         irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.WIDTH(W)) u_gpio_irq_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin),
    .wr_en_i   (wr_en),
    .wr_reg_i  (wr_reg),
    .wr_op_i   (wr_op),
    .wr_data_i (wr_data),
    .status_o  (status),
    .irq_o     (irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] r, input logic [1:0] o, input logic [W-1:0] d);
    wr_en = 1'b1; wr_reg = r; wr_op = o; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 status", status, '0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    pin = '0; tick(); tick();
    chk("R1 unrouted falling", status, '0);
    pin = '1; tick();
  endtask

  task automatic t_falling();
    wr(RG_ROUTE, A_WR, ONES);
    tick();
    chk("R2 steady", status, '0);
    pin[3] = 1'b0; tick();
    chk("R2 falling latch", status, 32'h8);
    chk("R7 disabled irq", {31'd0, irq}, 32'd0);
    wr(RG_EN, A_WR, 32'h8);
    chk("R7 enabled irq", {31'd0, irq}, 32'd1);
    pin[3] = 1'b1; tick();
    chk("R2 rising ignored", status, 32'h8);
    wr(RG_STAT, A_CLR, 32'h8);
    chk("R8 clear", status, '0);
    chk("R7 irq drops", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_rising();
    wr(RG_POL, A_SET, ONES);
    pin[5] = 1'b0; tick();
    chk("R3 falling ignored", status, '0);
    pin[5] = 1'b1; tick();
    chk("R3 rising latch", status, 32'h20);
    wr(RG_STAT, A_CLR, ONES);
    tick(); tick();
    chk("R12 steady no retrigger", status, '0);
  endtask

  task automatic t_level();
    pin = '0; tick();
    wr(RG_STAT, A_CLR, ONES);
    wr(RG_LEV, A_SET, ONES);
    tick();
    chk("R5 low pins idle", status, '0);
    pin[7] = 1'b1; tick();
    chk("R5 high level latch", status, 32'h80);
    wr(RG_STAT, A_CLR, 32'h80);
    chk("R5 relatch while high", status, 32'h80);
    pin[7] = 1'b0; tick();
    wr(RG_STAT, A_CLR, ONES);
    chk("R5 clear after release", status, '0);
    wr(RG_POL, A_CLR, ONES);
    tick();
    chk("R4 low level all", status, ONES);
    pin = '1; tick();
    wr(RG_STAT, A_CLR, ONES);
    chk("R4 clear after release", status, '0);
  endtask

  task automatic t_unrouted();
    wr(RG_ROUTE, A_WR, 32'hFF);
    pin = '0; tick();
    chk("R6 only routed latch", status, 32'hFF);
    wr(RG_STAT, A_CLR, ONES);
    chk("R4 clear undone by level", status, 32'hFF);
    pin = '1; tick();
    wr(RG_STAT, A_CLR, ONES);
    chk("R6 cleared", status, '0);
  endtask

  task automatic t_sticky();
    wr(RG_LEV, A_CLR, ONES);
    wr(RG_ROUTE, A_WR, ONES);
    tick();
    pin[0] = 1'b0; tick();
    chk("R8 latch", status, 32'h1);
    wr(RG_STAT, A_WR, '0);
    chk("R8 plain write ignored", status, 32'h1);
    wr(RG_STAT, A_SET, ONES);
    chk("R8 set write ignored", status, 32'h1);
    wr(RG_STAT, A_NONE, ONES);
    chk("R9 reserved alias on status", status, 32'h1);
    wr(RG_POL, A_SET, 32'h1);
    tick();
    chk("R11 mode change keeps status", status, 32'h1);
    wr(RG_STAT, A_CLR, 32'h1);
    chk("R8 clear bit0", status, '0);
  endtask

  task automatic t_collide();
    wr(RG_POL, A_CLR, ONES);
    pin = '1; tick();
    chk("R10 idle", status, '0);
    pin[12] = 1'b0;
    wr(RG_STAT, A_CLR, 32'h1000);
    chk("R10 set beats clear", status, 32'h1000);
    wr(RG_STAT, A_CLR, ONES);
    pin = '1; tick();
  endtask

  task automatic t_alias();
    pin = '0; tick();
    chk("R9 all latched", status, ONES);
    wr(RG_EN, A_WR, '0);
    chk("R9 plain enable zero", {31'd0, irq}, 32'd0);
    wr(RG_EN, A_SET, 32'h200);
    chk("R9 set enable", {31'd0, irq}, 32'd1);
    wr(RG_EN, A_CLR, 32'h200);
    chk("R9 clear enable", {31'd0, irq}, 32'd0);
    wr(RG_EN, A_WR, 32'h8000_0000);
    chk("R9 plain enable", {31'd0, irq}, 32'd1);
    wr(RG_EN, A_NONE, '0);
    chk("R9 reserved alias on enable", {31'd0, irq}, 32'd1);
    wr(RG_ROUTE, A_CLR, ONES);
    wr(RG_STAT, A_CLR, ONES);
    pin = '1; tick();
    pin = '0; tick();
    chk("R9 route cleared", status, '0);
  endtask

  initial begin
    #(200000 * 10);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_falling();
    t_rising();
    t_level();
    t_unrouted();
    t_sticky();
    t_collide();
    t_alias();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule